// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a real-time clock that runs directly on a 32768 Hz timebase. It keeps the current time as six BCD bytes (seconds, minutes, hours, day of month, month, two-digit year). It counts in 24-hour form and handles month lengths and leap Februaries. A second set of six bytes holds an alarm time. The alarm fires only when every one of the six fields equals the current time. Software reaches the block through a simple word-addressed register bus with a combinational read port. Sticky event flags in a status word feed two level interrupt outputs: a periodic timer interrupt and an alarm interrupt.

All writes are refused until software writes a two-word unlock sequence. A busy flag warns software in the last timebase period before each count update, so it knows when the time bytes are about to change. A run bit in the control word starts and freezes the count. Writing the seconds byte restarts the sub-second prescaler, so the first increment comes one full second after the time is set.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. The control word (0x40) reads 0, the interrupt-enable word (0x48) reads 0, and the status word (0x44) reads 0x80. The six time bytes sit at 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). The alarm bytes sit at 0x20 through 0x34 in the same order.
- R2: Every register write is ignored until 0x83E70B13 has been written to 0x6C and then 0x95A4F1E0 to 0x70. A write to 0x70 that is not preceded by the first key does not unlock.
- R3: Writing any value other than 0x83E70B13 to 0x6C locks the registers again.
- R4: Control bit 0 runs the clock when 1 and freezes every time byte when 0. Status bit 1 reads the run bit.
- R5: While running, the seconds advance once every TICKS_PER_SEC clocks. A write to the seconds byte restarts that interval, so the next increment comes TICKS_PER_SEC clocks after the write.
- R6: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Control bit 3 (12-hour select) is ignored: it always reads 0 and counting stays 24-hour.
- R7: The day wraps to 01 after the last day of the month: 30 for April, June, September and November, 31 for the other long months. February ends on 29 when the two-digit year is divisible by 4 and on 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R8: Status bit 0 (busy) is 1 during exactly the last clock of each running second, the clock just before the time bytes change.
- R9: Status bits 2, 3, 4 and 5 latch, respectively, a seconds increment, a minute rollover, an hour rollover and a day rollover. Each is cleared by writing 1 to it.
- R10: Status bit 6 is set on the clock after all six alarm bytes first equal the time bytes. It is not set if any single field differs.
- R11: Status bit 7 (power-up) and status bit 6 are cleared by writing 1 to them. Bit 7 is set only by reset.
- R12: irq_alarm is high while status bit 6 and interrupt-enable bit 3 are both 1. irq_timer is high while status bit 2 and interrupt-enable bit 2 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz timebase, also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_timer | output | 1 | Periodic timer interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The calendar is exercised with directed end-of-period times. These include the last second of a century, the last second of February in leap and common years (year 00 among them), and the last second of a 30-day month. Together they separate correct month-length and carry logic from a counter that only wraps fields at fixed limits. Random start times biased toward 23:59:5x and month ends, advanced by one to three seconds, test the carry chain against an independent binary calendar model. Alarm cases pair a full match with a one-field miss, which tells an all-field comparator apart from a partial one. The lock tests cover the wrong key order and a wrong first key, which tells a two-step sequence apart from a single key check.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   localparam int NFIELD = 6;

   // Field order matches the word index of the time and alarm banks.
   typedef struct packed {
      logic [7:0] year;
      logic [7:0] mon;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } cal_t;

   localparam cal_t CAL_INIT = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                 hour: 8'h00, min: 8'h00, sec: 8'h00};

   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lock_e;

   localparam logic [7:0] OFS_CTRL = 8'h40;
   localparam logic [7:0] OFS_STAT = 8'h44;
   localparam logic [7:0] OFS_IEN  = 8'h48;
   localparam logic [7:0] OFS_KEYA = 8'h6C;
   localparam logic [7:0] OFS_KEYB = 8'h70;

   localparam logic [31:0] KEYA_VAL = 32'h83E7_0B13;
   localparam logic [31:0] KEYB_VAL = 32'h95A4_F1E0;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic leap_year(input logic [7:0] y);
      logic [7:0] b;
      b = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
      return (b[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic busy,
   output logic tick
);
   localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

   if (TICKS_PER_SEC < 4) begin : g_bad_ticks
      $error("bcd_rtc_prescaler: TICKS_PER_SEC must be at least 4");
   end

   logic [CW-1:0] cnt_q;

   // The update window is the final period of the second; the update lands on its closing edge.
   assign busy = run && (cnt_q == LAST);
   assign tick = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (run)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
   import bcd_rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_en,
   input  logic [2:0] wr_idx,
   input  logic [7:0] wr_val,
   output cal_t       now,
   output logic       ev_min,
   output logic       ev_hour,
   output logic       ev_day
);
   cal_t now_q, nxt;
   logic c_min, c_hour, c_day, c_mon, c_year;

   always_comb begin
      nxt    = now_q;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;
      if (tick) begin
         if (now_q.sec == 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
         else                           nxt.sec = bcd_inc(now_q.sec);
         if (c_min) begin
            if (now_q.min == 8'h59) begin nxt.min = 8'h00; c_hour = 1'b1; end
            else                           nxt.min = bcd_inc(now_q.min);
         end
         if (c_hour) begin
            if (now_q.hour == 8'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
            else                            nxt.hour = bcd_inc(now_q.hour);
         end
         if (c_day) begin
            if (now_q.day >= month_last(now_q.mon, now_q.year)) begin
               nxt.day = 8'h01;
               c_mon   = 1'b1;
            end else begin
               nxt.day = bcd_inc(now_q.day);
            end
         end
         if (c_mon) begin
            if (now_q.mon >= 8'h12) begin nxt.mon = 8'h01; c_year = 1'b1; end
            else                           nxt.mon = bcd_inc(now_q.mon);
         end
         if (c_year) begin
            nxt.year = (now_q.year == 8'h99) ? 8'h00 : bcd_inc(now_q.year);
         end
      end
      // A software write to a field takes that field; the others still follow the tick.
      if (wr_en) begin
         case (wr_idx)
            3'd0:    nxt.sec  = wr_val;
            3'd1:    nxt.min  = wr_val;
            3'd2:    nxt.hour = wr_val;
            3'd3:    nxt.day  = wr_val;
            3'd4:    nxt.mon  = wr_val;
            3'd5:    nxt.year = wr_val;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= CAL_INIT;
      else        now_q <= nxt;
   end

   assign now     = now_q;
   assign ev_min  = c_min;
   assign ev_hour = c_hour;
   assign ev_day  = c_day;

   a_r6_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && now_q.sec == 8'h59) |=> (now_q.sec == 8'h00));

endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
   import bcd_rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_idx,
   input  logic [7:0] wr_val,
   input  cal_t       now,
   output cal_t       alarm,
   output logic       match
);
   logic [NFIELD-1:0][7:0] now_a;
   logic [NFIELD-1:0][7:0] al_a;
   logic [NFIELD-1:0]      eq;

   assign now_a = now;

   for (genvar g = 0; g < NFIELD; g++) begin : g_fld
      localparam logic [7:0] RST = (g == 3 || g == 4) ? 8'h01 : 8'h00;
      logic [7:0] fld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              fld_q <= RST;
         else if (wr_en && wr_idx == 3'(g))       fld_q <= wr_val;
      end
      assign al_a[g] = fld_q;
      assign eq[g]   = (fld_q == now_a[g]);
   end

   assign alarm = al_a;
   assign match = &eq;

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import bcd_rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_timer,
   output logic              irq_alarm
);
   localparam int WI_W = ADDR_W - 2;

   if (ADDR_W < 7) begin : g_bad_aw
      $error("bcd_rtc: ADDR_W must reach the key words");
   end
   if (DATA_W < 32) begin : g_bad_dw
      $error("bcd_rtc: DATA_W must hold a 32-bit key");
   end

   // ---------------- address decode ----------------
   logic [WI_W-1:0] widx;
   logic            aligned, hit_time, hit_alarm, hit_ctrl, hit_stat, hit_ien;
   logic            hit_keya, hit_keyb;

   assign widx      = bus_addr[ADDR_W-1:2];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign hit_time  = aligned && (widx < WI_W'(6));
   assign hit_alarm = aligned && (widx >= WI_W'(8)) && (widx < WI_W'(14));
   assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_ien   = (bus_addr == ADDR_W'(OFS_IEN));
   assign hit_keya  = (bus_addr == ADDR_W'(OFS_KEYA));
   assign hit_keyb  = (bus_addr == ADDR_W'(OFS_KEYB));

   // ---------------- unlock sequencer ----------------
   lock_e lock_q;
   logic  wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= LK_SHUT;
      end else if (bus_we && hit_keya) begin
         lock_q <= (bus_wdata == DATA_W'(KEYA_VAL)) ? LK_HALF : LK_SHUT;
      end else if (bus_we && hit_keyb && lock_q == LK_HALF) begin
         lock_q <= (bus_wdata == DATA_W'(KEYB_VAL)) ? LK_OPEN : LK_SHUT;
      end
   end

   assign wr_ok = bus_we && (lock_q == LK_OPEN);

   // ---------------- control and enables ----------------
   logic run_q, ie_alarm_q, ie_timer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         ie_alarm_q <= 1'b0;
         ie_timer_q <= 1'b0;
      end else begin
         if (wr_ok && hit_ctrl) run_q <= bus_wdata[0];
         if (wr_ok && hit_ien) begin
            ie_alarm_q <= bus_wdata[3];
            ie_timer_q <= bus_wdata[2];
         end
      end
   end

   // ---------------- counting datapath ----------------
   logic wr_time, wr_alarm, restart, busy, tick;
   logic ev_min, ev_hour, ev_day, match, match_q;
   cal_t now, alarm;

   assign wr_time  = wr_ok && hit_time;
   assign wr_alarm = wr_ok && hit_alarm;
   assign restart  = wr_time && (widx[2:0] == 3'd0);

   bcd_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .restart (restart),
      .busy    (busy),
      .tick    (tick)
   );

   bcd_rtc_calendar u_cal (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_time),
      .wr_idx  (widx[2:0]),
      .wr_val  (bus_wdata[7:0]),
      .now     (now),
      .ev_min  (ev_min),
      .ev_hour (ev_hour),
      .ev_day  (ev_day)
   );

   bcd_rtc_alarm u_alm (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_alarm),
      .wr_idx (widx[2:0]),
      .wr_val (bus_wdata[7:0]),
      .now    (now),
      .alarm  (alarm),
      .match  (match)
   );

   // ---------------- status flags ----------------
   // ev_q bit order: [5] power-up, [4] alarm, [3] day, [2] hour, [1] minute, [0] second.
   logic [5:0] ev_q, ev_set, ev_clr;

   assign ev_set = {1'b0, match & ~match_q, ev_day, ev_hour, ev_min, tick};
   assign ev_clr = (wr_ok && hit_stat) ? bus_wdata[7:2] : 6'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q    <= 6'b10_0000;
         match_q <= 1'b1;
      end else begin
         ev_q    <= (ev_q & ~ev_clr) | ev_set;
         match_q <= match;
      end
   end

   assign irq_timer = ev_q[0] & ie_timer_q;
   assign irq_alarm = ev_q[4] & ie_alarm_q;

   // ---------------- read port ----------------
   logic [NFIELD-1:0][7:0] now_a, al_a;
   assign now_a = now;
   assign al_a  = alarm;

   always_comb begin
      bus_rdata = '0;
      if (hit_time)       bus_rdata[7:0] = now_a[widx[2:0]];
      else if (hit_alarm) bus_rdata[7:0] = al_a[widx[2:0]];
      else if (hit_ctrl)  bus_rdata[0]   = run_q;
      else if (hit_stat)  bus_rdata[7:0] = {ev_q, run_q, busy};
      else if (hit_ien)   bus_rdata[3:2] = {ie_alarm_q, ie_timer_q};
   end

   // ---------------- checks ----------------
   a_r2_locked_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q != LK_OPEN && bus_we && hit_ctrl) |=> $stable(run_q));

   a_r3_bad_key_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_keya && bus_wdata != DATA_W'(KEYA_VAL)) |=> (lock_q == LK_SHUT));

   a_r8_update_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(now.sec) |-> ($past(busy) || $past(wr_time)));

   a_r10_alarm_from_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_q[4]) |-> $past(match));

   a_r11_powerup_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(ev_q[5]));

endmodule

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int TPS = 4;
   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam logic [31:0] KA = 32'h83E7_0B13;
   localparam logic [31:0] KB = 32'h95A4_F1E0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_timer, irq_alarm;

   always #2 clk = ~clk;

   bcd_rtc #(.TICKS_PER_SEC(TPS), .ADDR_W(AW), .DATA_W(DW)) u_bcd_rtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_timer (irq_timer),
      .irq_alarm (irq_alarm)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   int e_y, e_mo, e_d, e_h, e_mi, e_s;

   function automatic int to_bcd(int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   function automatic int mdays(int mo, int y);
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      return 31;
   endfunction

   task automatic model_tick();
      e_s++;
      if (e_s == 60) begin
         e_s = 0; e_mi++;
         if (e_mi == 60) begin
            e_mi = 0; e_h++;
            if (e_h == 24) begin
               e_h = 0; e_d++;
               if (e_d > mdays(e_mo, e_y)) begin
                  e_d = 1; e_mo++;
                  if (e_mo == 13) begin
                     e_mo = 1;
                     e_y = (e_y + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_we    = 1'b1;
      bus_addr  = AW'(a);
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic unlock();
      wr(8'h6C, KA);
      wr(8'h70, KB);
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      e_y = y; e_mo = mo; e_d = d; e_h = h; e_mi = mi; e_s = s;
      wr(8'h14, 32'(to_bcd(y)));
      wr(8'h10, 32'(to_bcd(mo)));
      wr(8'h0C, 32'(to_bcd(d)));
      wr(8'h08, 32'(to_bcd(h)));
      wr(8'h04, 32'(to_bcd(mi)));
      wr(8'h00, 32'(to_bcd(s)));
   endtask

   task automatic check_time(string req);
      logic [31:0] v;
      rd(8'h00, v); check(req, "seconds", v, 32'(to_bcd(e_s)));
      rd(8'h04, v); check(req, "minutes", v, 32'(to_bcd(e_mi)));
      rd(8'h08, v); check(req, "hours",   v, 32'(to_bcd(e_h)));
      rd(8'h0C, v); check(req, "day",     v, 32'(to_bcd(e_d)));
      rd(8'h10, v); check(req, "month",   v, 32'(to_bcd(e_mo)));
      rd(8'h14, v); check(req, "year",    v, 32'(to_bcd(e_y)));
   endtask

   // Runs for exactly n seconds from a freshly restarted prescaler, then stops.
   task automatic run_secs(int n);
      wr(8'h40, 32'h1);
      repeat (n * TPS) @(negedge clk);
      wr(8'h40, 32'h0);
      repeat (n) model_tick();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      logic [31:0] v;
      v = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      rd(8'h44, v); check("R1", "status", v, 32'h80);
      rd(8'h40, v); check("R1", "ctrl", v, 32'h0);
      rd(8'h48, v); check("R1", "ien", v, 32'h0);
      e_y = 0; e_mo = 1; e_d = 1; e_h = 0; e_mi = 0; e_s = 0;
      check_time("R1");
      check("R1", "irq lines", {30'd0, irq_timer, irq_alarm}, 32'h0);

      // R2: locked writes are dropped; second key alone does nothing
      wr(8'h00, 32'h30);
      rd(8'h00, v); check("R2", "write while locked", v, 32'h0);
      wr(8'h70, KB);
      wr(8'h00, 32'h30);
      rd(8'h00, v); check("R2", "second key only", v, 32'h0);
      unlock();
      wr(8'h00, 32'h30);
      rd(8'h00, v); check("R2", "write after unlock", v, 32'h30);

      // R3: wrong first key relocks
      wr(8'h6C, 32'h1234_5678);
      wr(8'h00, 32'h45);
      rd(8'h00, v); check("R3", "write after bad key", v, 32'h30);
      unlock();

      // Move the alarm away from the reset time so rollover tests do not hit it
      wr(8'h34, 32'h50);

      // R11: power-up flag clears on write-one
      wr(8'h44, 32'h80);
      rd(8'h44, v); check("R11", "power-up cleared", v, 32'h0);

      // R6: 12-hour select ignored, hours pass 12
      set_time(30, 7, 15, 12, 59, 59);
      wr(8'h40, 32'h8);
      rd(8'h40, v); check("R6", "mode bit reads 0", v, 32'h0);
      run_secs(1);
      check_time("R6");

      // R4: stopped clock holds
      repeat (5 * TPS) @(negedge clk);
      check_time("R4 frozen");
      rd(8'h44, v); check("R4", "run bit when stopped", v & 32'h3, 32'h0);

      // R8 / R4: busy only in the final clock of the second
      set_time(30, 1, 1, 0, 0, 0);
      wr(8'h40, 32'h1);
      repeat (TPS - 2) @(negedge clk);
      rd(8'h44, v); check("R8", "busy early", v & 32'h3, 32'h2);
      @(negedge clk);
      rd(8'h44, v); check("R8", "busy last clock", v & 32'h3, 32'h3);
      @(negedge clk);
      rd(8'h44, v); check("R8", "busy after update", v & 32'h3, 32'h2);
      @(negedge clk);
      rd(8'h00, v); check("R8", "seconds after busy", v, 32'h01);
      wr(8'h40, 32'h0);

      // R7 / R9: century rollover and event flags
      set_time(99, 12, 31, 23, 59, 59);
      wr(8'h44, 32'h3C);
      run_secs(1);
      check_time("R7 century");
      rd(8'h44, v); check("R9", "event flags", v, 32'h3C);
      wr(8'h44, 32'h3C);
      rd(8'h44, v); check("R9", "event flags cleared", v, 32'h0);

      // R7: month lengths and leap years
      set_time(24, 2, 28, 23, 59, 59); run_secs(1); check_time("R7 leap 28");
      set_time(24, 2, 29, 23, 59, 59); run_secs(1); check_time("R7 leap 29");
      set_time(23, 2, 28, 23, 59, 59); run_secs(1); check_time("R7 common feb");
      set_time(0, 2, 28, 23, 59, 59);  run_secs(1); check_time("R7 year 00");
      set_time(30, 4, 30, 23, 59, 59); run_secs(1); check_time("R7 april");

      // R5: seconds write restarts the prescaler
      set_time(40, 3, 3, 3, 3, 10);
      wr(8'h40, 32'h1);
      @(negedge clk);
      wr(8'h00, 32'h20);
      repeat (TPS - 1) @(negedge clk);
      rd(8'h00, v); check("R5", "no early tick", v, 32'h20);
      @(negedge clk);
      rd(8'h00, v); check("R5", "tick after full second", v, 32'h21);
      wr(8'h40, 32'h0);

      // R10 / R12: alarm at 25-06-07 08:10:00
      wr(8'h48, 32'h8);
      wr(8'h34, 32'h25); wr(8'h30, 32'h06); wr(8'h2C, 32'h07);
      wr(8'h28, 32'h08); wr(8'h24, 32'h10); wr(8'h20, 32'h00);
      rd(8'h34, v); check("R10", "alarm year readback", v, 32'h25);
      wr(8'h44, 32'h7C);
      set_time(25, 6, 7, 8, 9, 58); run_secs(1);
      rd(8'h44, v); check("R10", "no alarm one second early", v & 32'h40, 32'h0);
      check("R12", "irq_alarm low", {31'd0, irq_alarm}, 32'h0);
      set_time(25, 6, 7, 8, 9, 59); run_secs(1);
      rd(8'h44, v); check("R10", "alarm on full match", v & 32'h40, 32'h40);
      check("R12", "irq_alarm high", {31'd0, irq_alarm}, 32'h1);
      wr(8'h44, 32'h40);
      rd(8'h44, v); check("R11", "alarm flag cleared", v & 32'h40, 32'h0);
      check("R12", "irq_alarm dropped", {31'd0, irq_alarm}, 32'h0);

      // R10: one field differs -> no alarm
      wr(8'h34, 32'h26);
      set_time(25, 6, 7, 8, 9, 59); run_secs(1);
      rd(8'h44, v); check("R10", "year mismatch", v & 32'h40, 32'h0);

      // R12: disabled enable masks the line
      wr(8'h34, 32'h25);
      wr(8'h48, 32'h0);
      set_time(25, 6, 7, 8, 9, 59); run_secs(1);
      rd(8'h44, v); check("R10", "flag with enable off", v & 32'h40, 32'h40);
      check("R12", "irq_alarm masked", {31'd0, irq_alarm}, 32'h0);
      wr(8'h44, 32'h40);

      // R12 / R9: timer interrupt follows seconds flag
      wr(8'h44, 32'h3C);
      wr(8'h48, 32'h4);
      check("R12", "irq_timer before tick", {31'd0, irq_timer}, 32'h0);
      set_time(11, 11, 11, 11, 11, 11); run_secs(1);
      check("R12", "irq_timer after tick", {31'd0, irq_timer}, 32'h1);
      wr(8'h44, 32'h04);
      check("R12", "irq_timer cleared", {31'd0, irq_timer}, 32'h0);
      wr(8'h48, 32'h0);

      // R6 / R7: random start times biased to period ends
      for (int i = 0; i < 30; i++) begin
         int y, mo, d, h, mi, s, n;
         y  = int'($urandom % 100);
         mo = 1 + int'($urandom % 12);
         d  = ($urandom % 2 == 0) ? mdays(mo, y) : 1 + int'($urandom % 28);
         h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
         mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
         s  = 59 - int'($urandom % 3);
         n  = 1 + int'($urandom % 3);
         set_time(y, mo, d, h, mi, s);
         run_secs(n);
         check_time("R7 random");
      end

      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

endmodule